// File: doc/BRIEF.md
# Bridge Error Status and Interrupt Register

This block is the single global status/control word of a bus-bridge target. It records four error conditions as sticky flags: a parity error seen on the bus, a system error seen on the bus, an internal error during a target access, and the loss of a delayed-read completion whose requester never came back. Software reads the word through a plain read/write port and clears a flag by writing a one to it. Each flag has its own enable, and one registered interrupt request goes out whenever an enabled flag is set.

The block also owns the retry watchdog for the delayed-read buffer. When a delayed-read completion becomes ready the watchdog starts counting bus clocks. If the requester retries first, the count is dropped. If the timeout is reached first, the block pulses a flush to free the buffer and sets the discard flag in the same cycle. Two 3-bit clock-ratio codes are taken from straps while reset is held. One is a read-only detected ratio. The other is a programmable field whose value after reset comes from the straps.

Top module: `brg_err_stat`

## Requirements
- R1: While reset is held, the ratio straps are captured. After reset, the read word shows bit 0 = 1, the detected ratio at bits 26:24, the programmable ratio at bits 18:16, and every other bit 0. `irq` and `dr_flush` are low.
- R2: A pulse on `perr_evt`, `serr_evt` or `terr_evt` sets bit 29, bit 28 or bit 27 respectively at the next rising edge. The bit then stays set with no further events.
- R3: A write with a one in flag bit 31, 29, 28 or 27 clears that flag. A zero in a flag bit, or a one in a flag bit that is already clear, leaves the flag unchanged.
- R4: When a set event and a clearing write hit the same flag at the same edge, the flag ends up set.
- R5: Bits 15, 13, 12 and 11 are read/write enables for the discard, parity, system-error and error-response flags. Bits 18:16 and bit 0 are read/write. A write updates all of these at once.
- R6: Bits 26:24 hold the detected ratio code (001=/1, 010=/2, 011=/3, 100=/4, 101=/5, 110=/1.5; 000 and 111 are reserved). Writes do not change this field.
- R7: Bits 30, 23:19, 14 and 10:1 always read as zero, whatever was written to them.
- R8: `irq` is a register. It is high in the cycle after any flag and its enable are both set. It goes low in the cycle after no enabled flag remains set.
- R9: If `dr_ready` is not followed by `dr_retry`, then exactly 32768 rising edges after the edge that sampled `dr_ready`, `dr_flush` is high for one cycle and bit 31 sets at that same edge.
- R10: A `dr_retry` before the timeout edge, or on the timeout edge itself, cancels the watchdog: no flush, and bit 31 is not set. A retry with nothing pending has no effect.
- R11: A new `dr_ready` while a completion is pending restarts the 32768-edge count from that edge.
- R12: Changes on the strap inputs after reset is released do not alter bits 26:24 or 18:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with `clk` |
| reg_we | input | 1 | Write strobe for the status/control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current value of the status/control word |
| perr_evt | input | 1 | Parity-error event pulse |
| serr_evt | input | 1 | System-error event pulse |
| terr_evt | input | 1 | Internal target error pulse |
| dr_ready | input | 1 | A delayed-read completion has become ready |
| dr_retry | input | 1 | The requester has retried and taken the completion |
| strap_ratio | input | 3 | Detected clock-ratio code, sampled during reset |
| strap_prog | input | 3 | Reset value for the programmable ratio field |
| dr_flush | output | 1 | One-cycle pulse that frees the delayed-read buffer |
| irq | output | 1 | Registered interrupt request |

## Verification
The read word is built from registers only, so a write or event that is sampled at a rising edge appears on `reg_rdata` right after that edge. `irq` trails the flag it reflects by one further edge. `dr_flush` and the discard flag change together on the 32768th edge after the ready strobe. The bench applies stimulus on the falling edge and runs a requirement-level model one edge ahead. After each rising edge it queues the expected word, `irq` and `dr_flush`, and the monitor compares them on the following falling edge. Because of this, every cycle of the long watchdog waits is checked, including the edges on either side of the timeout.

// File: rtl/brg_pkg.sv
package brg_pkg;
  localparam int DATA_W    = 32;
  localparam int NFLAG     = 4;
  localparam int DIV_W     = 3;
  localparam int RATIO_LSB = 24;
  localparam int PROG_LSB  = 16;
  localparam int CTL0_POS  = 0;
  localparam int EN_SHIFT  = 16;

  typedef enum int {EV_DISCARD = 0, EV_PERR = 1, EV_SERR = 2, EV_TERR = 3} ev_idx_e;

  typedef enum logic [DIV_W-1:0] {
    DIV_RSV_LO = 3'b000, DIV_BY1 = 3'b001, DIV_BY2 = 3'b010, DIV_BY3 = 3'b011,
    DIV_BY4    = 3'b100, DIV_BY5 = 3'b101, DIV_BY1P5 = 3'b110, DIV_RSV_HI = 3'b111
  } div_code_e;

  function automatic int flag_pos(input int idx);
    case (idx)
      EV_DISCARD: return 31;
      EV_PERR:    return 29;
      EV_SERR:    return 28;
      default:    return 27;
    endcase
  endfunction

  function automatic int en_pos(input int idx);
    return flag_pos(idx) - EN_SHIFT;
  endfunction
endpackage

// File: rtl/brg_flag_bank.sv
module brg_flag_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic flag_q, flag_n, upd;

    always_comb begin
      upd    = set_i[g] | clr_i[g];
      flag_n = (flag_q & ~clr_i[g]) | set_i[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag_q <= 1'b0;
      else if (upd) flag_q <= flag_n;
    end

    assign flag_o[g] = flag_q;
  end
endmodule

// File: rtl/brg_rd_watchdog.sv
module brg_rd_watchdog #(
  parameter int TIMEOUT_CYC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ready_i,
  input  logic retry_i,
  output logic expire_o,
  output logic flush_o
);
  localparam int CW = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic          pend_q, pend_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          flush_q;
  logic          cnt_en;

  always_comb begin
    expire_o = pend_q && (cnt_q == LAST) && !retry_i && !ready_i;
    cnt_en   = ready_i | retry_i | pend_q;
    pend_n   = pend_q;
    cnt_n    = cnt_q;
    if (ready_i) begin
      pend_n = 1'b1;
      cnt_n  = '0;
    end else if (retry_i || expire_o) begin
      pend_n = 1'b0;
      cnt_n  = '0;
    end else if (pend_q) begin
      cnt_n  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cnt_en) begin
      pend_q <= pend_n;
      cnt_q  <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flush_q <= 1'b0;
    else        flush_q <= expire_o;
  end

  assign flush_o = flush_q;
endmodule

// File: rtl/brg_ctl_regs.sv
module brg_ctl_regs
  import brg_pkg::*;
#(
  parameter int N = NFLAG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [N-1:0]     en_wr_i,
  input  logic [DIV_W-1:0] prog_wr_i,
  input  logic             ctl0_wr_i,
  input  logic [DIV_W-1:0] strap_ratio_i,
  input  logic [DIV_W-1:0] strap_prog_i,
  output logic [N-1:0]     en_o,
  output logic [DIV_W-1:0] prog_o,
  output logic             ctl0_o,
  output logic [DIV_W-1:0] ratio_o
);
  logic [N-1:0]     en_q;
  logic             ctl0_q;
  logic [DIV_W-1:0] prog_q, prog_n;
  logic [DIV_W-1:0] ratio_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      ctl0_q <= 1'b1;
    end else if (we_i) begin
      en_q   <= en_wr_i;
      ctl0_q <= ctl0_wr_i;
    end
  end

  // Strap-loaded fields take the strap value on every edge while reset is low.
  always_comb begin
    prog_n = prog_q;
    if (!rst_n)    prog_n = strap_prog_i;
    else if (we_i) prog_n = prog_wr_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || we_i) prog_q <= prog_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ratio_q <= strap_ratio_i;
  end

  assign en_o    = en_q;
  assign prog_o  = prog_q;
  assign ctl0_o  = ctl0_q;
  assign ratio_o = ratio_q;
endmodule

// File: rtl/brg_err_stat.sv
module brg_err_stat
  import brg_pkg::*;
#(
  parameter int TIMEOUT_CYC = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              perr_evt,
  input  logic              serr_evt,
  input  logic              terr_evt,
  input  logic              dr_ready,
  input  logic              dr_retry,
  input  logic [DIV_W-1:0]  strap_ratio,
  input  logic [DIV_W-1:0]  strap_prog,
  output logic              dr_flush,
  output logic              irq
);
  logic [NFLAG-1:0] set_v, clr_v, flag_v, en_wr_v, en_v;
  logic [DIV_W-1:0] prog_v, ratio_v;
  logic             ctl0_v;
  logic             expire;
  logic             irq_q, irq_n;
  logic             unused_wbits;

  for (genvar g = 0; g < NFLAG; g++) begin : g_map
    assign clr_v[g]   = reg_we & reg_wdata[flag_pos(g)];
    assign en_wr_v[g] = reg_wdata[en_pos(g)];
  end

  assign set_v = {terr_evt, serr_evt, perr_evt, expire};

  assign unused_wbits = ^{reg_wdata[30], reg_wdata[26:19], reg_wdata[14], reg_wdata[10:1]};

  brg_rd_watchdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wdog (
    .clk      (clk),
    .rst_n    (rst_n),
    .ready_i  (dr_ready),
    .retry_i  (dr_retry),
    .expire_o (expire),
    .flush_o  (dr_flush)
  );

  brg_flag_bank #(.N(NFLAG)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_v),
    .clr_i  (clr_v),
    .flag_o (flag_v)
  );

  brg_ctl_regs #(.N(NFLAG)) u_ctl (
    .clk           (clk),
    .rst_n         (rst_n),
    .we_i          (reg_we),
    .en_wr_i       (en_wr_v),
    .prog_wr_i     (reg_wdata[PROG_LSB +: DIV_W]),
    .ctl0_wr_i     (reg_wdata[CTL0_POS]),
    .strap_ratio_i (strap_ratio),
    .strap_prog_i  (strap_prog),
    .en_o          (en_v),
    .prog_o        (prog_v),
    .ctl0_o        (ctl0_v),
    .ratio_o       (ratio_v)
  );

  always_comb irq_n = |(flag_v & en_v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_n;
  end

  assign irq = irq_q;

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NFLAG; i++) begin
      reg_rdata[flag_pos(i)] = flag_v[i];
      reg_rdata[en_pos(i)]   = en_v[i];
    end
    reg_rdata[RATIO_LSB +: DIV_W] = ratio_v;
    reg_rdata[PROG_LSB +: DIV_W]  = prog_v;
    reg_rdata[CTL0_POS]           = ctl0_v;
  end
endmodule

// File: rtl/brg_err_stat_chk.sv
module brg_err_stat_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] rdata,
  input logic        perr_evt,
  input logic        serr_evt,
  input logic        terr_evt,
  input logic        clr_perr,
  input logic        clr_terr,
  input logic        dr_ready,
  input logic        dr_retry,
  input logic        dr_flush,
  input logic        irq
);
  localparam logic [31:0] RSVD = 32'h40F8_47FE;

  logic [3:0] flags, ens;
  logic       armed;

  assign flags = {rdata[27], rdata[28], rdata[29], rdata[31]};
  assign ens   = {rdata[11], rdata[12], rdata[13], rdata[15]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_rsvd_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & RSVD) == 32'h0);

  p_perr_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    perr_evt |=> rdata[29]);

  p_serr_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    serr_evt |=> rdata[28]);

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[29] && !clr_perr) |=> rdata[29]);

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (terr_evt && clr_terr) |=> rdata[27]);

  p_ratio_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> $stable(rdata[26:24]));

  p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags & ens)) |=> irq);

  p_irq_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(flags & ens)) |=> !irq);

  p_flush_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dr_flush |-> rdata[31]);

  p_flush_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dr_flush |=> !dr_flush);

  p_retry_cancels_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_retry && !dr_ready) |=> !dr_flush);
endmodule

bind brg_err_stat brg_err_stat_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rdata    (reg_rdata),
  .perr_evt (perr_evt),
  .serr_evt (serr_evt),
  .terr_evt (terr_evt),
  .clr_perr (reg_we & reg_wdata[29]),
  .clr_terr (reg_we & reg_wdata[27]),
  .dr_ready (dr_ready),
  .dr_retry (dr_retry),
  .dr_flush (dr_flush),
  .irq      (irq)
);

// File: tb/test_brg_err_stat.sv
module test_brg_err_stat;
  localparam int TO = 32768;
  localparam int FP [4] = '{31, 29, 28, 27};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        perr_evt, serr_evt, terr_evt, dr_ready, dr_retry;
  logic [2:0]  strap_ratio, strap_prog;
  logic        dr_flush, irq;

  always #2.5 clk = ~clk;

  brg_err_stat i_brg_err_stat (
    .clk (clk), .rst_n (rst_n), .reg_we (reg_we), .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata), .perr_evt (perr_evt), .serr_evt (serr_evt),
    .terr_evt (terr_evt), .dr_ready (dr_ready), .dr_retry (dr_retry),
    .strap_ratio (strap_ratio), .strap_prog (strap_prog),
    .dr_flush (dr_flush), .irq (irq)
  );

  typedef struct {
    logic [31:0] rd;
    logic        irq;
    logic        flush;
    string       req;
  } exp_t;

  exp_t q[$];
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 0;

  logic [3:0] m_flag, m_en;
  logic [2:0] m_prog, m_ratio;
  logic       m_b0, m_irq, m_flush, m_pend;
  int         m_cnt;

  function automatic logic [31:0] model_rd();
    logic [31:0] r = '0;
    for (int i = 0; i < 4; i++) begin
      r[FP[i]]      = m_flag[i];
      r[FP[i] - 16] = m_en[i];
    end
    r[26:24] = m_ratio;
    r[18:16] = m_prog;
    r[0]     = m_b0;
    return r;
  endfunction

  function automatic void compare(input exp_t e);
    n_run++;
    if (reg_rdata !== e.rd || irq !== e.irq || dr_flush !== e.flush) begin
      n_fail++;
      $display("FAIL %s: rdata=%h irq=%b flush=%b expected rdata=%h irq=%b flush=%b",
               e.req, reg_rdata, irq, dr_flush, e.rd, e.irq, e.flush);
    end
  endfunction

  // Monitor: compares queued expectations on the falling edge.
  always @(negedge clk) begin
    while (q.size() > 0) compare(q.pop_front());
  end

  task automatic step(input logic we, input logic [31:0] wd, input logic pe,
                      input logic se, input logic te, input logic rdy,
                      input logic rty, input string req);
    logic [3:0] set_v, clr_v, nflag, nen;
    logic [2:0] nprog;
    logic       nb0, nirq, expv, npend;
    int         ncnt;
    exp_t       e;
    @(negedge clk);
    reg_we = we; reg_wdata = wd; perr_evt = pe; serr_evt = se; terr_evt = te;
    dr_ready = rdy; dr_retry = rty;
    expv  = m_pend && (m_cnt == TO - 1) && !rty && !rdy;
    set_v = {te, se, pe, expv};
    for (int i = 0; i < 4; i++) clr_v[i] = we && wd[FP[i]];
    nflag = (m_flag & ~clr_v) | set_v;
    nirq  = |(m_flag & m_en);
    nen = m_en; nprog = m_prog; nb0 = m_b0;
    if (we) begin
      for (int i = 0; i < 4; i++) nen[i] = wd[FP[i] - 16];
      nprog = wd[18:16];
      nb0   = wd[0];
    end
    npend = m_pend; ncnt = m_cnt;
    if (rdy) begin npend = 1'b1; ncnt = 0; end
    else if (rty || expv) begin npend = 1'b0; ncnt = 0; end
    else if (m_pend) ncnt = m_cnt + 1;
    @(posedge clk);
    #1;
    m_flag = nflag; m_en = nen; m_prog = nprog; m_b0 = nb0; m_irq = nirq;
    m_flush = expv; m_pend = npend; m_cnt = ncnt;
    e.rd = model_rd(); e.irq = m_irq; e.flush = m_flush; e.req = req;
    q.push_back(e);
  endtask

  task automatic idle(input int n, input string req);
    for (int k = 0; k < n; k++) step(1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, req);
  endtask

  task automatic wr(input logic [31:0] wd, input string req);
    step(1'b1, wd, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, req);
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 0; reg_wdata = 0; perr_evt = 0; serr_evt = 0;
    terr_evt = 0; dr_ready = 0; dr_retry = 0;
    strap_ratio = 3'b110; strap_prog = 3'b011;
    m_flag = 0; m_en = 0; m_prog = 3'b011; m_ratio = 3'b110; m_b0 = 1;
    m_irq = 0; m_flush = 0; m_pend = 0; m_cnt = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    begin
      exp_t e;
      e.rd = 32'h0603_0001; e.irq = 0; e.flush = 0; e.req = "R1 reset state";
      compare(e);
    end
    // R12: strap changes after reset are ignored
    strap_ratio = 3'b001; strap_prog = 3'b101;
    idle(2, "R12 straps ignored after reset");
    // R5 R6 R7: all-ones write, then all-zeros write
    wr(32'hFFFF_FFFF, "R5 R6 R7 write all ones");
    wr(32'h0000_0000, "R5 R6 R7 write all zeros");
    wr(32'h0005_0001, "R5 prog field and bit0");
    // R2: events set flags and stay
    step(0, 0, 1, 0, 0, 0, 0, "R2 parity event");
    step(0, 0, 0, 1, 0, 0, 0, "R2 system error event");
    step(0, 0, 0, 0, 1, 0, 0, "R2 target error event");
    idle(3, "R2 flags sticky");
    // R3: write zero, then clear one flag
    wr(32'h0005_0001, "R3 zero write leaves flags");
    wr(32'h2005_0001, "R3 clear parity flag only");
    wr(32'h2005_0001, "R3 clear already-clear flag");
    // R8: interrupt path
    wr(32'h0005_1001, "R8 enable system error");
    idle(2, "R8 irq high");
    wr(32'h1005_1001, "R8 clear system error flag");
    idle(2, "R8 irq low after clear");
    step(0, 0, 1, 0, 0, 0, 0, "R8 parity event while disabled");
    wr(32'h0005_2001, "R8 enable parity");
    idle(1, "R8 irq from parity");
    wr(32'h0005_0001, "R8 drop enable");
    idle(2, "R8 irq low after enable drop");
    // R4: set and clear together
    step(1, 32'h0805_0001, 0, 0, 1, 0, 0, "R4 set wins over clear");
    idle(1, "R4 flag still set");
    wr(32'h2805_8001, "R4 clear flags, enable discard");
    // R9: full timeout
    step(0, 0, 0, 0, 0, 1, 0, "R9 ready");
    idle(TO + 2, "R9 timeout flush and flag");
    wr(32'h8000_8001, "R9 clear discard flag");
    // R10: early retry, retry at expiry edge, retry with nothing pending
    step(0, 0, 0, 0, 0, 1, 0, "R10 ready");
    idle(100, "R10 waiting");
    step(0, 0, 0, 0, 0, 0, 1, "R10 early retry");
    idle(TO - 98, "R10 no flush after cancel");
    step(0, 0, 0, 0, 0, 1, 0, "R10 ready again");
    idle(TO - 1, "R10 waiting to expiry");
    step(0, 0, 0, 0, 0, 0, 1, "R10 retry on expiry edge");
    idle(3, "R10 no flush");
    step(0, 0, 0, 0, 0, 0, 1, "R10 stray retry");
    idle(2, "R10 stray retry no effect");
    // R11: restart on second ready
    step(0, 0, 0, 0, 0, 1, 0, "R11 first ready");
    idle(20000, "R11 partial wait");
    step(0, 0, 0, 0, 0, 1, 0, "R11 second ready");
    idle(TO + 2, "R11 flush timed from second ready");
    idle(1, "R11 drain");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R9 R10 R11: run did not end, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule